// File: doc/BRIEF.md
# Parallel Panel Write-Cycle Sequencer

This block turns single write requests from a host into complete 8080-style write cycles on a parallel display-panel bus. The host offers a data word and a command/data select bit on a valid/ready handshake. Once a request is accepted, the block drives the select bit and data word onto the bus. It then lowers chip select and pulses the write strobe. Last, it raises chip select again. Both strobes are active low and rest high.

Each write cycle has four timed phases, and each phase length comes from its own 4-bit configuration input. The phase lasts the programmed value plus one clock. The four phases are:
- the settle time of the select bit before chip select falls;
- the delay from chip select falling to the strobe falling;
- the strobe low time;
- the delay from the strobe rising to chip select rising.

The configuration is captured when a request is accepted. Changing it during a cycle therefore only affects the next one. After reset, the usual setting is 0 for the three setup and hold fields and 1 for the strobe-low field.

Top module: `i80_wr_seq`

## Requirements
- R1: While `rst_n` is low and immediately after it is released, `lcd_cs_n` and `lcd_wr_n` are 1, `req_ready` is 1, and `lcd_dc` and `lcd_data` are 0.
- R2: A request is accepted at a rising clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the first cycle in which `lcd_cs_n` is high again. `req_ready` is 1 in that cycle.
- R3: After acceptance, `lcd_cs_n` stays high for exactly `cfg_addr_setup`+1 cycles. `lcd_dc` and `lcd_data` already show the accepted values in the first of those cycles.
- R4: After `lcd_cs_n` falls, `lcd_wr_n` stays high for exactly `cfg_cs_to_wr`+1 cycles before it falls.
- R5: `lcd_wr_n` stays low for exactly `cfg_wr_low`+1 cycles. A value of 0 gives a one-cycle pulse.
- R6: After `lcd_wr_n` rises, `lcd_cs_n` stays low for exactly `cfg_wr_to_cs`+1 cycles and then goes high.
- R7: `lcd_dc` and `lcd_data` are captured at acceptance. They hold those values, without change, until `lcd_cs_n` has returned high.
- R8: The four configuration fields are captured at acceptance. Changing them during a cycle does not change that cycle's phase lengths.
- R9: `lcd_wr_n` is low only while `lcd_cs_n` is low. With `req_valid` held high, consecutive cycles leave `lcd_cs_n` high for at least one cycle between them.
- R10: Each configuration field is a 4-bit unsigned count. A value of 15 gives a 16-cycle phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock; all phase lengths count its cycles |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Host offers a write request |
| req_ready | output | 1 | Sequencer can accept a request |
| req_dc | input | 1 | Command/data select bit of the request |
| req_data | input | DATA_W | Data word of the request |
| cfg_addr_setup | input | 4 | Select-bit settle time before chip select falls, minus one |
| cfg_cs_to_wr | input | 4 | Chip-select-low to strobe-low delay, minus one |
| cfg_wr_low | input | 4 | Strobe low time, minus one |
| cfg_wr_to_cs | input | 4 | Strobe-high to chip-select-high delay, minus one |
| lcd_dc | output | 1 | Command/data select on the panel bus |
| lcd_data | output | DATA_W | Data word on the panel bus |
| lcd_cs_n | output | 1 | Chip select, active low |
| lcd_wr_n | output | 1 | Write strobe, active low |

## Verification
The assertions check the cycle-level rules on every clock:
- the strobe is low only inside chip select;
- `req_ready` is high only on an idle bus and falls right after acceptance;
- the bus values are frozen while chip select is low;
- at least one cycle separates chip select falling from the strobe falling, and the strobe rising from chip select rising;
- the phase counter never exceeds its captured limit.

The exact length of each phase, the capture of the configuration at acceptance, and the back-to-back gap can only be shown by the bench's scenarios. The bench counts these cycles at the ports for all-zero, mixed and all-15 settings, and again with the configuration changed in the middle of a cycle.

// File: rtl/i80_wr_pkg.sv
package i80_wr_pkg;

  parameter int unsigned PH_W = 4;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ADDR  = 3'd1,
    PH_CSSU  = 3'd2,
    PH_ACT   = 3'd3,
    PH_HOLD  = 3'd4
  } phase_e;

  typedef struct packed {
    logic [PH_W-1:0] addr_setup;
    logic [PH_W-1:0] cs_to_wr;
    logic [PH_W-1:0] wr_low;
    logic [PH_W-1:0] wr_to_cs;
  } timing_t;

endpackage

// File: rtl/i80_phase_ctrl.sv
module i80_phase_ctrl
  import i80_wr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  input  timing_t cfg_in,
  output logic    accept,
  output logic    idle,
  output phase_e  phase_nxt
);

  phase_e          phase_q, phase_d;
  logic [PH_W-1:0] cnt_q, cnt_d;
  timing_t         tim_q, tim_d;
  logic            cnt_en;
  logic            tim_en;

  function automatic logic [PH_W-1:0] phase_len(input phase_e ph, input timing_t t);
    case (ph)
      PH_ADDR: phase_len = t.addr_setup;
      PH_CSSU: phase_len = t.cs_to_wr;
      PH_ACT:  phase_len = t.wr_low;
      PH_HOLD: phase_len = t.wr_to_cs;
      default: phase_len = '0;
    endcase
  endfunction

  function automatic phase_e phase_after(input phase_e ph);
    case (ph)
      PH_ADDR: phase_after = PH_CSSU;
      PH_CSSU: phase_after = PH_ACT;
      PH_ACT:  phase_after = PH_HOLD;
      default: phase_after = PH_IDLE;
    endcase
  endfunction

  assign idle   = (phase_q == PH_IDLE);
  assign accept = idle && req_valid;

  // next-state logic
  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    tim_d   = tim_q;
    cnt_en  = 1'b0;
    tim_en  = 1'b0;
    if (phase_q == PH_IDLE) begin
      if (accept) begin
        phase_d = PH_ADDR;
        tim_d   = cfg_in;
        tim_en  = 1'b1;
        cnt_d   = cfg_in.addr_setup;
        cnt_en  = 1'b1;
      end
    end else begin
      cnt_en = 1'b1;
      if (cnt_q != '0) begin
        cnt_d = cnt_q - 1'b1;
      end else begin
        phase_d = phase_after(phase_q);
        cnt_d   = phase_len(phase_after(phase_q), tim_q);
      end
    end
  end

  assign phase_nxt = phase_d;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      tim_q   <= '0;
    end else begin
      phase_q <= phase_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (tim_en) tim_q <= tim_d;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE) |-> (cnt_q <= phase_len(phase_q, tim_q))); // R10

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE && $past(phase_q) != PH_IDLE) |-> $stable(tim_q)); // R8

endmodule

// File: rtl/i80_bus_regs.sv
module i80_bus_regs
  import i80_wr_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              dc_in,
  input  logic [DATA_W-1:0] data_in,
  input  phase_e            phase_nxt,
  output logic              dc_q,
  output logic [DATA_W-1:0] data_q,
  output logic              cs_n_q,
  output logic              wr_n_q
);

  logic cs_n_d;
  logic wr_n_d;

  always_comb begin
    cs_n_d = !((phase_nxt == PH_CSSU) || (phase_nxt == PH_ACT) || (phase_nxt == PH_HOLD));
    wr_n_d = (phase_nxt != PH_ACT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_q <= 1'b1;
      wr_n_q <= 1'b1;
    end else begin
      cs_n_q <= cs_n_d;
      wr_n_q <= wr_n_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dc_q   <= 1'b0;
      data_q <= '0;
    end else if (load_en) begin
      dc_q   <= dc_in;
      data_q <= data_in;
    end
  end

endmodule

// File: rtl/i80_wr_seq.sv
module i80_wr_seq
  import i80_wr_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_dc,
  input  logic [DATA_W-1:0] req_data,
  input  logic [PH_W-1:0]   cfg_addr_setup,
  input  logic [PH_W-1:0]   cfg_cs_to_wr,
  input  logic [PH_W-1:0]   cfg_wr_low,
  input  logic [PH_W-1:0]   cfg_wr_to_cs,
  output logic              lcd_dc,
  output logic [DATA_W-1:0] lcd_data,
  output logic              lcd_cs_n,
  output logic              lcd_wr_n
);

  timing_t cfg_bus;
  logic    accept;
  logic    idle;
  phase_e  phase_nxt;

  assign cfg_bus = '{addr_setup: cfg_addr_setup, cs_to_wr: cfg_cs_to_wr,
                     wr_low: cfg_wr_low, wr_to_cs: cfg_wr_to_cs};

  i80_phase_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .cfg_in    (cfg_bus),
    .accept    (accept),
    .idle      (idle),
    .phase_nxt (phase_nxt)
  );

  i80_bus_regs #(.DATA_W(DATA_W)) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (accept),
    .dc_in     (req_dc),
    .data_in   (req_data),
    .phase_nxt (phase_nxt),
    .dc_q      (lcd_dc),
    .data_q    (lcd_data),
    .cs_n_q    (lcd_cs_n),
    .wr_n_q    (lcd_wr_n)
  );

  assign req_ready = idle;

  AST_WR_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_wr_n |-> !lcd_cs_n); // R9

  AST_READY_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (lcd_cs_n && lcd_wr_n)); // R2

  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R2

  AST_BUS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_cs_n |-> ($stable(lcd_data) && $stable(lcd_dc))); // R7

  AST_WR_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_wr_n) |-> $past(!lcd_cs_n)); // R4

  AST_CS_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_cs_n) |-> $past(lcd_wr_n)); // R6

endmodule

// File: tb/i80_wr_seq_bench.sv
`timescale 1ns/1ps
module i80_wr_seq_bench;

  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic          req_dc;
  logic [DW-1:0] req_data;
  logic [3:0]    cfg_a, cfg_b, cfg_c, cfg_e;
  logic          lcd_dc;
  logic [DW-1:0] lcd_data;
  logic          lcd_cs_n;
  logic          lcd_wr_n;

  int checks = 0;
  int errors = 0;
  int m_pre, m_su, m_act, m_hold;
  bit m_gap_high;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  i80_wr_seq #(.DATA_W(DW)) u_i80_wr_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_dc(req_dc), .req_data(req_data),
    .cfg_addr_setup(cfg_a), .cfg_cs_to_wr(cfg_b), .cfg_wr_low(cfg_c), .cfg_wr_to_cs(cfg_e),
    .lcd_dc(lcd_dc), .lcd_data(lcd_data), .lcd_cs_n(lcd_cs_n), .lcd_wr_n(lcd_wr_n)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Called at a negedge. Returns at the negedge where chip select is back high.
  task automatic run_xfer(input logic dc, input logic [DW-1:0] d,
                          input logic [3:0] a, input logic [3:0] b,
                          input logic [3:0] c, input logic [3:0] e,
                          input bit perturb, input bit keep_valid);
    int guard;
    bit done;
    req_dc = dc; req_data = d; req_valid = 1'b1;
    cfg_a = a; cfg_b = b; cfg_c = c; cfg_e = e;
    guard = 0;
    while (!req_ready && guard < 100) begin @(negedge clk); guard++; end
    @(negedge clk);
    chk(req_ready == 1'b0, "R2", "ready after accept", req_ready, 0);
    chk(lcd_dc == dc, "R3", "dc valid before cs", lcd_dc, dc);
    chk(lcd_data == d, "R3", "data valid before cs", lcd_data, d);
    if (!keep_valid) req_valid = 1'b0;
    if (perturb) begin cfg_a = ~a; cfg_b = ~b; cfg_c = ~c; cfg_e = ~e; end
    m_pre = 0; m_su = 0; m_act = 0; m_hold = 0; done = 1'b0;
    for (int i = 0; i < 200 && !done; i++) begin
      if (!lcd_cs_n && lcd_wr_n && m_act == 0) m_su++;
      else if (!lcd_cs_n && !lcd_wr_n) m_act++;
      else if (!lcd_cs_n && lcd_wr_n) m_hold++;
      else if (lcd_cs_n && m_su == 0) m_pre++;
      else done = 1'b1;
      if (!done) begin
        if (lcd_data != d || lcd_dc != dc) begin
          chk(1'b0, "R7", "bus word changed", lcd_data, d);
        end
        if (req_ready) chk(1'b0, "R2", "ready during cycle", req_ready, 0);
        if (!lcd_wr_n && lcd_cs_n) chk(1'b0, "R9", "strobe outside cs", lcd_cs_n, 0);
        @(negedge clk);
      end
    end
    m_gap_high = lcd_cs_n && lcd_wr_n;
    chk(req_ready == 1'b1, "R2", "ready when cs high", req_ready, 1);
    chk(lcd_data == d, "R7", "data after cs high", lcd_data, d);
  endtask

  task automatic chk_len(input int pre, input int su, input int act, input int hold,
                         input string tag);
    chk(m_pre == pre, tag, "R3 addr phase", m_pre, pre);
    chk(m_su == su, tag, "R4 cs-to-wr phase", m_su, su);
    chk(m_act == act, tag, "R5 wr-low phase", m_act, act);
    chk(m_hold == hold, tag, "R6 wr-to-cs phase", m_hold, hold);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; req_valid = 1'b0; req_dc = 1'b0; req_data = '0;
    cfg_a = 4'd0; cfg_b = 4'd0; cfg_c = 4'd1; cfg_e = 4'd0;
    repeat (3) @(negedge clk);
    chk(lcd_cs_n == 1'b1 && lcd_wr_n == 1'b1, "R1", "strobes in reset", {lcd_cs_n, lcd_wr_n}, 3);
    chk(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(lcd_dc == 1'b0 && lcd_data == '0, "R1", "bus cleared", lcd_data, 0);
    chk(lcd_cs_n == 1'b1 && lcd_wr_n == 1'b1, "R1", "strobes after reset", {lcd_cs_n, lcd_wr_n}, 3);
  endtask

  task automatic t_defaults;
    run_xfer(1'b0, 16'h00A5, 4'd0, 4'd0, 4'd1, 4'd0, 1'b0, 1'b0);
    chk_len(1, 1, 2, 1, "R5");
  endtask

  task automatic t_min_pulse;
    run_xfer(1'b1, 16'h1234, 4'd0, 4'd0, 4'd0, 4'd0, 1'b0, 1'b0);
    chk_len(1, 1, 1, 1, "R5");
  endtask

  task automatic t_mixed;
    run_xfer(1'b1, 16'hBEEF, 4'd2, 4'd3, 4'd5, 4'd4, 1'b0, 1'b0);
    chk_len(3, 4, 6, 5, "R3");
  endtask

  task automatic t_max;
    run_xfer(1'b0, 16'hFFFF, 4'd15, 4'd15, 4'd15, 4'd15, 1'b0, 1'b0);
    chk_len(16, 16, 16, 16, "R10");
  endtask

  task automatic t_cfg_change;
    run_xfer(1'b1, 16'h5A5A, 4'd1, 4'd2, 4'd3, 4'd6, 1'b1, 1'b0);
    chk_len(2, 3, 4, 7, "R8");
  endtask

  task automatic t_back2back;
    run_xfer(1'b0, 16'h0F0F, 4'd0, 4'd1, 4'd0, 4'd2, 1'b0, 1'b1);
    chk_len(1, 2, 1, 3, "R9");
    chk(m_gap_high, "R9", "cs high between cycles", m_gap_high, 1);
    run_xfer(1'b1, 16'hF0F0, 4'd0, 4'd1, 4'd0, 4'd2, 1'b0, 1'b0);
    chk_len(1, 2, 1, 3, "R9");
    chk(lcd_dc == 1'b1, "R7", "second dc captured", lcd_dc, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_defaults();
    t_min_pulse();
    t_mixed();
    t_max();
    t_cfg_change();
    t_back2back();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule